// File: doc/BRIEF.md
# Level Interrupt Aggregator with Status and Enable Words

This block gathers a set of level-type interrupt lines from peripherals (32 by default, one bit per line) and presents them to a CPU interrupt controller as a single chained request. Each line first passes through one register stage. It then sets a sticky bit in a pending status word, and that bit stays set until software clears it. A second word, the enable mask, selects which pending bits may raise the chained request. Line 5 is reserved by convention for the CPU performance-counter overflow.

Software reaches both words through a small register bus. A write takes effect at the clock edge on which `bus_wr` is high. A read is combinational from `bus_addr`. To acknowledge a line, software reads the status word, clears the bit in its copy, and writes the word back. Bits written as one keep their value and bits written as zero are cleared. To bring the block up, software writes zero to the enable word and then zero to the status word.

Top module: `misc_irq_aggregator`

## Requirements
- R1: After reset, the status word, the enable word and `irq_o` are all zero.
- R2: The status word sits at byte address 0x0 and the enable word at byte address 0x4. Bit n of each word belongs to source line n. A read returns the current content of the selected word, so a read in the cycle after a write returns the value written.
- R3: Any other address (0x8, 0xC and the rest) reads as zero. A write to such an address changes neither word.
- R4: A write to address 0x4 replaces the whole enable word with `bus_wdata`.
- R5: When a source line is high before a clock edge, its status bit reads as one after the second following edge. The bit then stays set after the line falls, until software clears it.
- R6: A write to address 0x0 clears each status bit written as zero. Each bit written as one keeps its current value, and a one never sets a clear bit.
- R7: If a synchronised source is high in the same cycle that software clears its bit, the bit stays set.
- R8: `irq_o` is high exactly when status AND enable is nonzero, delayed by one clock cycle from a change in either word.
- R9: Writing zero to the enable word and then zero to the status word, with all sources low, leaves both words at zero and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (4) | Byte address for reads and writes |
| bus_wdata | input | NUM_SRC (32) | Write data |
| bus_rdata | output | NUM_SRC (32) | Read data for `bus_addr` |
| src_i | input | NUM_SRC (32) | Level interrupt lines, bit n is source n |
| irq_o | output | 1 | Chained interrupt request to the parent controller |

## Verification
A stuck or lost status bit shows up at the next read of address 0x0. A status bit that is wrong in the enable-masked positions also shows on `irq_o` exactly one edge after the faulty update. An enable word corrupted by a misdecoded write shows up in a read of 0x4 on the very next cycle, and in `irq_o` one edge later. The sharpest timing checks are the two-edge set latency, the one-edge output latency, and a clear that loses to a still-active source.

// File: rtl/misc_irq_pkg.sv
// Package: shared constants and types of the interrupt aggregator.
// Assumes byte addressing and one bit per source in each register word.
package misc_irq_pkg;
    localparam int unsigned DEF_NUM_SRC = 32;
    localparam int unsigned DEF_ADDR_W  = 4;
    localparam int unsigned STATUS_OFF  = 0;
    localparam int unsigned ENABLE_OFF  = 4;
    localparam int unsigned PERF_SRC    = 5;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic wr_status;
        logic wr_enable;
    } wr_strobe_t;
endpackage

// File: rtl/misc_irq_sync.sv
// Module: one register stage on every source line before the status logic.
// Assumes the sources are level-type and already in the clk domain.
module misc_irq_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic q_r;
        // Capture one source line per cycle
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= 1'b0;
            else        q_r <= d_i[g];
        end
        assign q_o[g] = q_r;
    end
endmodule

// File: rtl/misc_irq_decode.sv
// Module: address decode, write strobes and read mux.
// Assumes full byte address compare; unmapped offsets read zero.
module misc_irq_decode
    import misc_irq_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  status_i,
    input  logic [WIDTH-1:0]  enable_i,
    output wr_strobe_t        strobe_o,
    output logic [WIDTH-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_OFF);
    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(ENABLE_OFF);

    reg_sel_e sel;

    // Map the address to a register select
    always_comb begin
        if (addr_i == ST_ADDR)      sel = SEL_STATUS;
        else if (addr_i == EN_ADDR) sel = SEL_ENABLE;
        else                        sel = SEL_NONE;
    end

    // Qualify the write strobe with the select
    always_comb begin
        strobe_o.wr_status = wr_i && (sel == SEL_STATUS);
        strobe_o.wr_enable = wr_i && (sel == SEL_ENABLE);
    end

    // Return the selected word, zero for unmapped
    always_comb begin
        case (sel)
            SEL_STATUS: rdata_o = status_i;
            SEL_ENABLE: rdata_o = enable_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/misc_irq_regs.sv
// Module: sticky pending status word and enable mask.
// Assumes a write to status keeps bits written one and clears bits written zero;
// a synchronised source that is high wins over a clear in the same cycle.
module misc_irq_regs
    import misc_irq_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strobe_t       strobe_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] enable_o
);
    logic [WIDTH-1:0] status_r, status_nx;
    logic [WIDTH-1:0] enable_r;

    // Next status: masked keep on write, then OR in active sources
    always_comb begin
        status_nx = strobe_i.wr_status ? (status_r & wdata_i) : status_r;
        status_nx = status_nx | src_i;
    end

    // Hold the status word
    always_ff @(posedge clk) begin
        if (!rst_n) status_r <= '0;
        else        status_r <= status_nx;
    end

    // Hold the enable word, replaced whole on write
    always_ff @(posedge clk) begin
        if (!rst_n)                  enable_r <= '0;
        else if (strobe_i.wr_enable) enable_r <= wdata_i;
    end

    assign status_o = status_r;
    assign enable_o = enable_r;
endmodule

// File: rtl/misc_irq_out.sv
// Module: registered chained request from status AND enable.
// Assumes one cycle of latency is acceptable to the parent controller.
module misc_irq_out #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] enable_i,
    output logic             irq_o
);
    logic active;
    logic irq_r;

    // Any pending and enabled source
    always_comb active = |(status_i & enable_i);

    // Register the request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_r <= 1'b0;
        else        irq_r <= active;
    end

    assign irq_o = irq_r;
endmodule

// File: rtl/misc_irq_aggregator.sv
// Module: top of the level interrupt aggregator.
// Assumes a single clock, synchronous active-low reset, one-cycle write strobes.
module misc_irq_aggregator
    import misc_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned ADDR_W  = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    wr_strobe_t         strobe;

    misc_irq_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (src_i),
        .q_o  (src_q)
    );

    misc_irq_decode #(.WIDTH(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .status_i(status_q),
        .enable_i(enable_q),
        .strobe_o(strobe),
        .rdata_o (bus_rdata)
    );

    misc_irq_regs #(.WIDTH(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(strobe),
        .wdata_i (bus_wdata),
        .src_i   (src_q),
        .status_o(status_q),
        .enable_o(enable_q)
    );

    misc_irq_out #(.WIDTH(NUM_SRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .status_i(status_q),
        .enable_i(enable_q),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/misc_irq_checker.sv
// Module: temporal checks on the aggregator, attached by bind.
// Assumes the top-level signal names src_q, status_q and enable_q.
module misc_irq_checker #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_SRC-1:0] wdata,
    input logic [NUM_SRC-1:0] src_q,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] enable,
    input logic               irq_o
);
    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(4);

    a_r4_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == EN_ADDR) |=> (enable == $past(wdata)));

    a_r3_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != EN_ADDR && addr != ST_ADDR) |=> $stable(enable));

    a_r5_set_only_from_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(src_q)) == '0));

    a_r6_clear_follows_wdata: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ST_ADDR) |=> ((status & ~$past(wdata) & ~$past(src_q)) == '0));

    a_r7_source_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & $past(src_q)) == $past(src_q)));

    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & enable)) |=> irq_o);

    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & enable)) |=> !irq_o);
endmodule

bind misc_irq_aggregator misc_irq_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .src_q (src_q),
    .status(status_q),
    .enable(enable_q),
    .irq_o (irq_o)
);

// File: tb/sim_misc_irq_aggregator.sv
module sim_misc_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_i = '0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    misc_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i), .irq_o(irq_o)
    );

    // vector: enable, source pulse, status write-back, expected status, expected irq
    typedef struct packed {
        logic [31:0] en;
        logic [31:0] src;
        logic [31:0] clr;
        logic [31:0] exp_st;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'hFFFFFFFF, 32'h00000020, 32'hFFFFFFFF, 32'h00000020, 1'b1},
        '{32'h00000000, 32'h80000001, 32'hFFFFFFFF, 32'h80000001, 1'b0},
        '{32'h0000FFFF, 32'hFFFF0000, 32'hFFFFFFFF, 32'hFFFF0000, 1'b0},
        '{32'hFFFF0000, 32'hF0F0F0F0, 32'h0F0FFFFF, 32'h0000F0F0, 1'b0},
        '{32'h00F00000, 32'h00A50000, 32'hFFFFFFFF, 32'h00A50000, 1'b1},
        '{32'h80000000, 32'h80000000, 32'h7FFFFFFF, 32'h00000000, 1'b0}
    };

    task automatic cycle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] r;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_reg(4'h0, r); chk32("R1 status", r, 32'h0);
        rd_reg(4'h4, r); chk32("R1 enable", r, 32'h0);
        chk1("R1 irq", irq_o, 1'b0);

        // Table walk: R5 sticky set, R6 masked clear, R8 output
        for (int v = 0; v < NV; v++) begin
            wr_reg(4'h4, VECS[v].en);
            rd_reg(4'h4, r); chk32("R2 enable readback", r, VECS[v].en);
            src_i = VECS[v].src;
            @(negedge clk);
            src_i = '0;
            cycle(2);
            rd_reg(4'h0, r); chk32("R5 sticky status", r, VECS[v].src);
            wr_reg(4'h0, VECS[v].clr);
            cycle(1);
            rd_reg(4'h0, r); chk32("R6 status after write", r, VECS[v].exp_st);
            chk1("R8 irq level", irq_o, VECS[v].exp_irq);
            wr_reg(4'h0, 32'h0);
            cycle(1);
        end

        // R8 exact latency: set at edge 2, irq at edge 3
        wr_reg(4'h4, 32'h00000008);
        src_i = 32'h00000008;
        @(negedge clk);
        rd_reg(4'h0, r); chk32("R5 not yet after one edge", r, 32'h0);
        src_i = '0;
        @(negedge clk);
        rd_reg(4'h0, r); chk32("R5 set after two edges", r, 32'h00000008);
        chk1("R8 irq still low", irq_o, 1'b0);
        @(negedge clk);
        chk1("R8 irq after one more edge", irq_o, 1'b1);
        wr_reg(4'h0, 32'h0);
        chk1("R8 irq holds one edge after clear", irq_o, 1'b1);
        @(negedge clk);
        chk1("R8 irq low after clear", irq_o, 1'b0);

        // R7 set wins over clear while source active
        src_i = 32'h00000004;
        cycle(3);
        wr_reg(4'h0, 32'h0);
        rd_reg(4'h0, r); chk32("R7 set wins", r, 32'h00000004);
        src_i = '0;
        cycle(2);
        wr_reg(4'h0, 32'h0);
        rd_reg(4'h0, r); chk32("R6 clear after source falls", r, 32'h0);

        // R3 unmapped read and write
        src_i = 32'h00000100;
        @(negedge clk);
        src_i = '0;
        cycle(2);
        wr_reg(4'h4, 32'h12345678);
        wr_reg(4'h8, 32'hFFFFFFFF);
        wr_reg(4'hC, 32'h00000000);
        rd_reg(4'h8, r); chk32("R3 unmapped read", r, 32'h0);
        rd_reg(4'h4, r); chk32("R3 enable untouched", r, 32'h12345678);
        rd_reg(4'h0, r); chk32("R3 status untouched", r, 32'h00000100);

        // R9 init sequence
        wr_reg(4'h4, 32'hFFFFFFFF);
        @(negedge clk);
        chk1("R9 irq before init", irq_o, 1'b1);
        wr_reg(4'h4, 32'h0);
        wr_reg(4'h0, 32'h0);
        @(negedge clk);
        rd_reg(4'h0, r); chk32("R9 status zero", r, 32'h0);
        rd_reg(4'h4, r); chk32("R9 enable zero", r, 32'h0);
        chk1("R9 irq low", irq_o, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule